// File: doc/BRIEF.md
# E-Paper Panel Reset and Ready-Wait Sequencer

This block drives the hardware reset line of an e-paper panel controller and watches the controller's active-high BUSY output. A host asks for a reset, which also serves as the only way to wake the panel from deep sleep. The block then produces a three-phase waveform on the reset line: high, then a short low pulse, then high again. After that it waits for BUSY to clear. A second request input starts only the ready-wait. The command issuer uses it right after it has sent an update-trigger (master activation) command.

All phase lengths and the ready-wait limit are counted in strobes of a 1 ms tick input, not in clock cycles. If BUSY is still high when the limit runs out, the block gives up and reports a timeout rather than hanging. Completion and timeout are each a one-cycle pulse. A request that arrives while a sequence is running is dropped, and the block flags it with a one-cycle reject pulse.

Top module: `epd_reset_sequencer`

## Requirements
- R1: After synchronous reset, `panel_rst_n` is 1 and `seq_active`, `seq_done`, `seq_timeout` and `req_reject` are all 0.
- R2: A `rst_req` accepted while idle holds `panel_rst_n` high for PRE_MS ticks, then low for LOW_MS ticks, then high for POST_MS ticks, and then enters the ready-wait. With a tick on every cycle and BUSY low, this gives 20 high samples, 2 low samples, and 21 high samples before the `seq_done` sample.
- R3: Phase lengths count `ms_tick` strobes. With a strobe every third cycle, the low phase lasts exactly 3*LOW_MS cycles. The time from the rising edge back to `seq_done` is exactly 3*POST_MS+1 cycles.
- R4: `panel_busy` passes through a two-flop synchronizer. When BUSY falls during a wait, `seq_done` is seen on the third clock edge after the change.
- R5: The wait ends when synchronized BUSY is low. `seq_done` pulses for exactly one cycle, and in that same cycle `seq_active` is already 0.
- R6: If BUSY stays high for TIMEOUT_MS ticks of the wait (10000 by default), `seq_timeout` pulses for one cycle, `seq_done` never pulses, and the block returns to idle.
- R7: An `act_start` accepted while idle enters the ready-wait directly and leaves `panel_rst_n` high throughout. If BUSY is already low, `seq_done` follows one cycle after acceptance.
- R8: A `rst_req` or `act_start` seen while `seq_active` is 1 does not alter the running sequence's timing or line level, and `req_reject` pulses in the next cycle.
- R9: If `rst_req` and `act_start` are both high in the same idle cycle, the reset waveform runs.
- R10: `seq_active` is 1 from the cycle after a request is accepted until the cycle in which `seq_done` or `seq_timeout` is raised, and `panel_rst_n` is low only while `seq_active` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_tick | input | 1 | One-cycle strobe every millisecond |
| rst_req | input | 1 | Request the reset/wake waveform followed by a ready-wait |
| act_start | input | 1 | Request a ready-wait after an update trigger |
| panel_busy | input | 1 | Panel BUSY, active high, asynchronous |
| panel_rst_n | output | 1 | Panel reset line level |
| seq_active | output | 1 | A sequence is running |
| seq_done | output | 1 | One-cycle pulse: ready-wait finished |
| seq_timeout | output | 1 | One-cycle pulse: BUSY never cleared |
| req_reject | output | 1 | One-cycle pulse: request dropped while active |

## Verification
Every output is registered, so a request sampled on one edge is first visible after that edge. A reject shows one sample later. A BUSY fall shows as `seq_done` after three edges: two in the synchronizer and one in the output register. A timeout shows on the edge of the 10000th tick of the wait. Each task drives inputs one time unit after an edge and samples one time unit after the next edge. It keeps a running sample index from the acceptance edge, so each phase length, latency and pulse width is compared against an exact sample number rather than a window.

// File: rtl/epd_seq_pkg.sv
package epd_seq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_PRE,
    PH_LOW,
    PH_POST,
    PH_WAIT
  } seq_ph_t;

  function automatic int max_of4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/epd_busy_sync.sv
module epd_busy_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic sync_out
);

  logic [STAGES-1:0] chain;

  // Resets to "busy" so a wait never completes on stale data.
  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-2:0], async_in};
  end

  assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/epd_tick_timer.sv
module epd_tick_timer #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         tick,
  input  logic [W-1:0] last,
  output logic         hit
);

  logic [W-1:0] cnt;

  assign hit = tick && (cnt == last);

  always_ff @(posedge clk) begin
    if (rst || clr || hit) cnt <= '0;
    else if (tick)         cnt <= cnt + 1'b1;
  end

  // R3
  cnt_within_limit_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= last);

endmodule

// File: rtl/epd_seq_ctrl.sv
module epd_seq_ctrl
  import epd_seq_pkg::*;
#(
  parameter int PRE_MS     = 20,
  parameter int LOW_MS     = 2,
  parameter int POST_MS    = 20,
  parameter int TIMEOUT_MS = 10000,
  parameter int W          = 14
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         rst_req,
  input  logic         act_start,
  input  logic         busy_s,
  input  logic         hit,
  output logic         tmr_clr,
  output logic [W-1:0] tmr_last,
  output logic         rst_line,
  output logic         active,
  output logic         done,
  output logic         err,
  output logic         bad_req
);

  seq_ph_t st, nxt;
  logic    done_n, err_n, bad_n;

  always_comb begin
    nxt    = st;
    done_n = 1'b0;
    err_n  = 1'b0;
    unique case (st)
      PH_IDLE: begin
        if (rst_req)        nxt = PH_PRE;
        else if (act_start) nxt = PH_WAIT;
      end
      PH_PRE:  if (hit) nxt = PH_LOW;
      PH_LOW:  if (hit) nxt = PH_POST;
      PH_POST: if (hit) nxt = PH_WAIT;
      PH_WAIT: begin
        if (!busy_s) begin
          nxt    = PH_IDLE;
          done_n = 1'b1;
        end else if (hit) begin
          nxt   = PH_IDLE;
          err_n = 1'b1;
        end
      end
      default: nxt = PH_IDLE;
    endcase
  end

  assign bad_n   = (st != PH_IDLE) && (rst_req || act_start);
  assign tmr_clr = (st == PH_IDLE) || (nxt != st);

  always_comb begin
    unique case (st)
      PH_PRE:  tmr_last = W'(PRE_MS - 1);
      PH_LOW:  tmr_last = W'(LOW_MS - 1);
      PH_POST: tmr_last = W'(POST_MS - 1);
      PH_WAIT: tmr_last = W'(TIMEOUT_MS - 1);
      default: tmr_last = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= PH_IDLE;
      rst_line <= 1'b1;
      active   <= 1'b0;
      done     <= 1'b0;
      err      <= 1'b0;
      bad_req  <= 1'b0;
    end else begin
      st       <= nxt;
      rst_line <= (nxt != PH_LOW);
      active   <= (nxt != PH_IDLE);
      done     <= done_n;
      err      <= err_n;
      bad_req  <= bad_n;
    end
  end

  // R8
  reject_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (active && (rst_req || act_start)) |=> bad_req);

  // R10
  low_only_active_chk: assert property (@(posedge clk) disable iff (rst)
    !rst_line |-> active);

  // R2
  rise_then_post_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_line) |-> (active && !done && !err));

  // R5
  end_clears_active_chk: assert property (@(posedge clk) disable iff (rst)
    (done || err) |-> !active);

  // R6
  single_outcome_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({done, err}));

endmodule

// File: rtl/epd_reset_sequencer.sv
module epd_reset_sequencer
  import epd_seq_pkg::*;
#(
  parameter int PRE_MS      = 20,
  parameter int LOW_MS      = 2,
  parameter int POST_MS     = 20,
  parameter int TIMEOUT_MS  = 10000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ms_tick,
  input  logic rst_req,
  input  logic act_start,
  input  logic panel_busy,
  output logic panel_rst_n,
  output logic seq_active,
  output logic seq_done,
  output logic seq_timeout,
  output logic req_reject
);

  localparam int MAX_T = max_of4(PRE_MS, LOW_MS, POST_MS, TIMEOUT_MS);
  localparam int W     = $clog2(MAX_T + 1);

  logic         busy_s;
  logic         hit;
  logic         tmr_clr;
  logic [W-1:0] tmr_last;

  epd_busy_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (panel_busy),
    .sync_out (busy_s)
  );

  epd_tick_timer #(.W(W)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .clr  (tmr_clr),
    .tick (ms_tick),
    .last (tmr_last),
    .hit  (hit)
  );

  epd_seq_ctrl #(
    .PRE_MS     (PRE_MS),
    .LOW_MS     (LOW_MS),
    .POST_MS    (POST_MS),
    .TIMEOUT_MS (TIMEOUT_MS),
    .W          (W)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .rst_req   (rst_req),
    .act_start (act_start),
    .busy_s    (busy_s),
    .hit       (hit),
    .tmr_clr   (tmr_clr),
    .tmr_last  (tmr_last),
    .rst_line  (panel_rst_n),
    .active    (seq_active),
    .done      (seq_done),
    .err       (seq_timeout),
    .bad_req   (req_reject)
  );

endmodule

// File: tb/sim_epd_reset_sequencer.sv
`timescale 1ns/1ps
module sim_epd_reset_sequencer;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ms_tick = 1'b0;
  logic rst_req = 1'b0;
  logic act_start = 1'b0;
  logic panel_busy = 1'b0;
  logic panel_rst_n, seq_active, seq_done, seq_timeout, req_reject;

  int checks = 0;
  int fails  = 0;
  int tick_per = 1;
  int tdiv = 0;

  always #2 clk = ~clk;

  always @(posedge clk) begin
    if (tdiv >= tick_per - 1) begin
      tdiv    <= 0;
      ms_tick <= 1'b1;
    end else begin
      tdiv    <= tdiv + 1;
      ms_tick <= 1'b0;
    end
  end

  epd_reset_sequencer u0 (
    .clk(clk), .rst(rst), .ms_tick(ms_tick), .rst_req(rst_req),
    .act_start(act_start), .panel_busy(panel_busy),
    .panel_rst_n(panel_rst_n), .seq_active(seq_active),
    .seq_done(seq_done), .seq_timeout(seq_timeout), .req_reject(req_reject)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic t_reset();
    chk("R1 rst line", panel_rst_n, 1);
    chk("R1 active", seq_active, 0);
    chk("R1 done", seq_done, 0);
    chk("R1 timeout", seq_timeout, 0);
    chk("R1 reject", req_reject, 0);
  endtask

  // R2 / R3: measure the three phases of the reset waveform
  task automatic t_rst_wave(input int per);
    int pre, low, post;
    tick_per = per;
    panel_busy = 1'b0;
    step();
    rst_req = 1'b1;
    step();
    rst_req = 1'b0;
    pre = 0; low = 0; post = 0;
    while (panel_rst_n && pre < 5000) begin pre++; step(); end
    while (!panel_rst_n && low < 5000) begin low++; step(); end
    while (!seq_done && post < 5000) begin post++; step(); end
    if (per == 1) begin
      chk("R2 pre high", pre, 20);
      chk("R2 low", low, 2);
      chk("R2 post high", post, 21);
    end else begin
      chk("R3 pre range", int'(pre >= 19*per + 1 && pre <= 20*per), 1);
      chk("R3 low ticks", low, 2*per);
      chk("R3 post ticks", post, 20*per + 1);
    end
    chk("R5 done active", seq_active, 0);
    step();
    chk("R5 done one cycle", seq_done, 0);
    tick_per = 1;
  endtask

  // R4 / R7: ready-wait only, BUSY drops after a while
  task automatic t_wait_latency();
    int n, lowseen;
    panel_busy = 1'b1;
    repeat (3) step();
    act_start = 1'b1;
    step();
    act_start = 1'b0;
    chk("R10 active after accept", seq_active, 1);
    lowseen = 0;
    for (int i = 0; i < 50; i++) begin
      if (!panel_rst_n || seq_done) lowseen++;
      step();
    end
    panel_busy = 1'b0;
    n = 0;
    while (!seq_done && n < 100) begin
      if (!panel_rst_n) lowseen++;
      n++;
      step();
    end
    chk("R4 sync latency", n, 3);
    chk("R7 line untouched", lowseen, 0);
    step();
  endtask

  // R5 / R7: BUSY already low at acceptance
  task automatic t_ready_now();
    panel_busy = 1'b0;
    repeat (3) step();
    act_start = 1'b1;
    step();
    act_start = 1'b0;
    chk("R7 wait entered", seq_active, 1);
    chk("R7 no instant done", seq_done, 0);
    step();
    chk("R7 done next cycle", seq_done, 1);
    chk("R5 idle with done", seq_active, 0);
    step();
    chk("R5 pulse width", seq_done, 0);
  endtask

  // R6: BUSY never clears
  task automatic t_timeout();
    int n, dn;
    panel_busy = 1'b1;
    repeat (3) step();
    act_start = 1'b1;
    step();
    act_start = 1'b0;
    n = 0; dn = 0;
    while (!seq_timeout && n < 20000) begin
      if (seq_done || !seq_active) dn++;
      n++;
      step();
    end
    chk("R6 timeout cycle", n, 10000);
    chk("R6 no done/active held", dn, 0);
    chk("R6 idle at timeout", seq_active, 0);
    step();
    chk("R6 pulse width", seq_timeout, 0);
    panel_busy = 1'b0;
    repeat (3) step();
  endtask

  // R8: requests during a running sequence are dropped
  task automatic t_reject();
    int idx, relow;
    panel_busy = 1'b1;
    step();
    rst_req = 1'b1;
    step();
    rst_req = 1'b0;
    idx = 0;
    while (idx < 20) begin step(); idx++; end
    chk("R8 in low phase", panel_rst_n, 0);
    act_start = 1'b1;
    step(); idx++;
    act_start = 1'b0;
    chk("R8 reject pulse", req_reject, 1);
    chk("R8 low kept", panel_rst_n, 0);
    step(); idx++;
    chk("R8 reject one cycle", req_reject, 0);
    chk("R8 low length kept", panel_rst_n, 1);
    relow = 0;
    while (idx < 45) begin
      if (!panel_rst_n || seq_done) relow++;
      step(); idx++;
    end
    rst_req = 1'b1;
    step(); idx++;
    rst_req = 1'b0;
    chk("R8 reject in wait", req_reject, 1);
    while (idx < 50) begin
      if (!panel_rst_n || seq_done) relow++;
      step(); idx++;
    end
    panel_busy = 1'b0;
    while (!seq_done && idx < 200) begin
      if (!panel_rst_n) relow++;
      step(); idx++;
    end
    chk("R8 done index", idx, 53);
    chk("R8 no restart", relow, 0);
    step();
  endtask

  // R9: simultaneous requests, reset has priority
  task automatic t_both();
    int pre, n;
    panel_busy = 1'b0;
    repeat (3) step();
    rst_req = 1'b1;
    act_start = 1'b1;
    step();
    rst_req = 1'b0;
    act_start = 1'b0;
    pre = 0;
    while (panel_rst_n && !seq_done && pre < 100) begin pre++; step(); end
    chk("R9 reset wins", pre, 20);
    chk("R9 line low", panel_rst_n, 0);
    n = 0;
    while (!seq_done && n < 100) begin n++; step(); end
    chk("R9 finishes", seq_done, 1);
    step();
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: got 1 expected 0");
    finish_run();
  end

  initial begin
    repeat (3) step();
    rst = 1'b0;
    step();
    t_reset();
    t_rst_wave(1);
    t_rst_wave(3);
    t_wait_latency();
    t_ready_now();
    t_timeout();
    t_reject();
    t_both();
    finish_run();
  end

endmodule